// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes a small 8-bit microcontroller core into an interrupt. It keeps a mask of pending hardware interrupt sources and a latched reset request. When the core may be interrupted, it chooses one request. The return program counter goes onto the data stack one byte per clock through a byte-wide memory write port, with the stack pointer moving down after each byte. The block then hands the core a new program counter at the chosen vector slot and tells it to clear its global interrupt enable flag.

The core drives its skip-pending state, global enable, current PC, stack pointer and two configuration inputs into the block. One input selects how many PC bytes are saved. The other selects whether vector slots are one word or two words wide. While a sequence is in flight, `busy_o` stalls the core. The core takes the new PC and the new stack pointer from the load strobes of the final cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: While `skip_i` is high, no entry starts, neither for reset nor for a hardware source. A request that arrives then stays pending, and entry begins once `skip_i` is low.
- R2: While `gie_i` is low, no entry starts, and pending requests are kept.
- R3: A reset request (a one-cycle pulse on `rst_req_i`) is latched until it is taken. It is chosen ahead of any hardware source and uses vector number 0, which gives a target PC of 0.
- R4: Among the pending hardware sources, the lowest set bit index i wins, and its vector number is i+1. The target PC is the vector number times 2 when `long_vec_i` is 1, and the vector number times 1 when it is 0.
- R5: When entry completes, only the winning bit is removed from `pend_o`. `hw_req_o` is high exactly when `pend_o` is non-zero.
- R6: The return PC is written least significant byte first, at addresses SP, SP-1, SP-2. `pc_bytes_i` = 3 writes bits 7:0, 15:8 and 23:16. A value of 2 writes the two lower bytes. A value of 1 or 0 writes only bits 7:0.
- R7: In the cycle after the last write, `pc_load_o`, `gie_clr_o` and `sp_load_o` are high for exactly one cycle. In that cycle `pc_o` holds the target PC and `sp_o` holds SP minus the number of bytes written.
- R8: `busy_o` is high from the first write cycle through the load cycle, and low in the next cycle. `mem_we_o` is high only in write cycles.
- R9: After synchronous reset `rst`, `busy_o`, `mem_we_o`, `pc_load_o` and `hw_req_o` are low, and `pend_o` is zero.
- R10: A pulse on `src_set_i` in the load cycle is kept in `pend_o`, even for the bit that is being cleared in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | One-cycle reset request pulse |
| src_set_i | input | NSRC | One-cycle pulses that mark sources pending |
| skip_i | input | 1 | An instruction skip is pending |
| gie_i | input | 1 | Global interrupt enable flag |
| pc_i | input | PCW | Current program counter (return address) |
| sp_i | input | SPW | Current stack pointer |
| pc_bytes_i | input | 2 | Number of PC bytes to save (3, 2, else 1) |
| long_vec_i | input | 1 | Two-word vector slots when 1 |
| busy_o | output | 1 | Sequence in flight; stalls the core |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_addr_o | output | SPW | Stack write address |
| mem_wdata_o | output | 8 | Stack write data |
| pc_load_o | output | 1 | Load `pc_o` into the program counter |
| pc_o | output | PCW | Vector target PC |
| gie_clr_o | output | 1 | Clear the global interrupt enable flag |
| sp_load_o | output | 1 | Load `sp_o` into the stack pointer |
| sp_o | output | SPW | Updated stack pointer |
| pend_o | output | NSRC | Pending source mask |
| hw_req_o | output | 1 | Any hardware source pending |

## Verification
Two functions can meet in one clock. A new source can be marked pending in the same load cycle in which the serviced bit is cleared from the mask. The bench provokes this by pulsing `src_set_i` exactly when it sees `pc_load_o`, once with the bit being cleared and once with another bit. After the edge it reads `pend_o` to check that the set has won. A second collision happens when a reset request and a hardware source are pending together at acceptance. That case is judged from the vector that is loaded and from the hardware bit that stays pending.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PUSH0  = 3'd1,
        ST_PUSH1  = 3'd2,
        ST_PUSH2  = 3'd3,
        ST_VECTOR = 3'd4
    } seq_state_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] pend_d, pend_q;

    // a fresh set outranks a clear of the same bit
    always_comb begin
        pend_d = (pend_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R5
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC = 32,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] req_i,
    output logic [NSRC-1:0] grant_o,
    output logic [IDXW-1:0] idx_o,
    output logic            any_o
);
    logic [NSRC:0] below;
    assign below[0] = 1'b0;

    for (genvar g = 0; g < NSRC; g++) begin : g_chain
        assign below[g+1]  = below[g] | req_i[g];
        assign grant_o[g]  = req_i[g] & ~below[g];
    end

    assign any_o = below[NSRC];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant_o[i]) idx_o = idx_o | IDXW'(i);
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int PCW  = 24,
    parameter int SPW  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rst_req_i,
    input  logic [NSRC-1:0] src_set_i,
    input  logic            skip_i,
    input  logic            gie_i,
    input  logic [PCW-1:0]  pc_i,
    input  logic [SPW-1:0]  sp_i,
    input  logic [1:0]      pc_bytes_i,
    input  logic            long_vec_i,
    output logic            busy_o,
    output logic            mem_we_o,
    output logic [SPW-1:0]  mem_addr_o,
    output logic [7:0]      mem_wdata_o,
    output logic            pc_load_o,
    output logic [PCW-1:0]  pc_o,
    output logic            gie_clr_o,
    output logic            sp_load_o,
    output logic [SPW-1:0]  sp_o,
    output logic [NSRC-1:0] pend_o,
    output logic            hw_req_o
);
    localparam int IDXW = $clog2(NSRC);
    localparam int VW   = $clog2(NSRC + 1);

    typedef struct packed {
        seq_state_e      st;
        logic            is_rst;
        logic            rst_pend;
        logic [NSRC-1:0] win;
        logic [IDXW-1:0] idx;
        logic [PCW-1:0]  ret_pc;
        logic [SPW-1:0]  sp;
        logic [1:0]      nbytes;
        logic            long_vec;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] grant;
    logic [IDXW-1:0] win_idx;
    logic            any_src;
    logic [NSRC-1:0] clr_mask;
    logic            take;
    logic [VW-1:0]   vec_num;
    logic [7:0]      pc_byte [3];

    irq_pend_reg #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (src_set_i),
        .clr_i  (clr_mask),
        .pend_o (pend)
    );

    irq_prio_pick #(.NSRC(NSRC)) u_pick (
        .req_i   (pend),
        .grant_o (grant),
        .idx_o   (win_idx),
        .any_o   (any_src)
    );

    for (genvar b = 0; b < 3; b++) begin : g_bytes
        assign pc_byte[b] = r_q.ret_pc[8*b +: 8];
    end

    assign take    = !skip_i && gie_i && (r_q.rst_pend || any_src);
    assign vec_num = r_q.is_rst ? '0 : VW'(r_q.idx) + VW'(1);

    always_comb begin
        r_d         = r_q;
        r_d.rst_pend = r_q.rst_pend | rst_req_i;
        mem_we_o    = 1'b0;
        mem_wdata_o = 8'h00;
        pc_load_o   = 1'b0;
        gie_clr_o   = 1'b0;
        sp_load_o   = 1'b0;
        clr_mask    = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (take) begin
                    r_d.st       = ST_PUSH0;
                    r_d.is_rst   = r_q.rst_pend;
                    r_d.win      = r_q.rst_pend ? '0 : grant;
                    r_d.idx      = win_idx;
                    r_d.ret_pc   = pc_i;
                    r_d.sp       = sp_i;
                    r_d.long_vec = long_vec_i;
                    r_d.nbytes   = (pc_bytes_i == 2'd3) ? 2'd3 :
                                   (pc_bytes_i == 2'd2) ? 2'd2 : 2'd1;
                end
            end
            ST_PUSH0: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = pc_byte[0];
                r_d.sp      = r_q.sp - SPW'(1);
                r_d.st      = (r_q.nbytes >= 2'd2) ? ST_PUSH1 : ST_VECTOR;
            end
            ST_PUSH1: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = pc_byte[1];
                r_d.sp      = r_q.sp - SPW'(1);
                r_d.st      = (r_q.nbytes == 2'd3) ? ST_PUSH2 : ST_VECTOR;
            end
            ST_PUSH2: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = pc_byte[2];
                r_d.sp      = r_q.sp - SPW'(1);
                r_d.st      = ST_VECTOR;
            end
            ST_VECTOR: begin
                pc_load_o = 1'b1;
                gie_clr_o = 1'b1;
                sp_load_o = 1'b1;
                clr_mask  = r_q.win;
                if (r_q.is_rst) r_d.rst_pend = rst_req_i;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
        end else begin
            r_q          <= r_d;
        end
    end

    assign busy_o     = (r_q.st != ST_IDLE);
    assign mem_addr_o = r_q.sp;
    assign sp_o       = r_q.sp;
    assign pc_o       = r_q.long_vec ? (PCW'(vec_num) << 1) : PCW'(vec_num);
    assign pend_o     = pend;
    assign hw_req_o   = |pend;

    AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && skip_i) |=> (r_q.st == ST_IDLE)); // R1
    AST_GIE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && !gie_i) |=> !busy_o); // R2
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R4
    AST_VEC_BOUND: assert property (@(posedge clk) disable iff (rst)
        (pc_load_o && !long_vec_i && !r_q.long_vec) |-> (pc_o <= PCW'(NSRC))); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - SPW'(1))); // R6
    AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !busy_o); // R8
    AST_RST_VEC: assert property (@(posedge clk) disable iff (rst)
        (pc_load_o && r_q.is_rst) |-> (pc_o == '0)); // R3
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    localparam int NSRC = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            rst_req_i = 1'b0;
    logic [NSRC-1:0] src_set_i = '0;
    logic            skip_i = 1'b0;
    logic            gie_i = 1'b0;
    logic [23:0]     pc_i = '0;
    logic [15:0]     sp_i = '0;
    logic [1:0]      pc_bytes_i = 2'd3;
    logic            long_vec_i = 1'b0;
    logic            busy_o, mem_we_o, pc_load_o, gie_clr_o, sp_load_o, hw_req_o;
    logic [15:0]     mem_addr_o, sp_o;
    logic [7:0]      mem_wdata_o;
    logic [23:0]     pc_o;
    logic [NSRC-1:0] pend_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .src_set_i(src_set_i),
        .skip_i(skip_i), .gie_i(gie_i), .pc_i(pc_i), .sp_i(sp_i),
        .pc_bytes_i(pc_bytes_i), .long_vec_i(long_vec_i), .busy_o(busy_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .pc_load_o(pc_load_o), .pc_o(pc_o), .gie_clr_o(gie_clr_o),
        .sp_load_o(sp_load_o), .sp_o(sp_o), .pend_o(pend_o), .hw_req_o(hw_req_o)
    );

    typedef struct packed {
        logic [31:0] mask;
        logic        rreq;
        logic [1:0]  nbyt;
        logic        lng;
        logic [23:0] pc;
        logic [15:0] sp;
        logic [5:0]  vec;
    } row_t;

    localparam row_t TBL [6] = '{
        row_t'{32'h0000_0001, 1'b0, 2'd3, 1'b1, 24'h123456, 16'h08FF, 6'd1},
        row_t'{32'h8000_0000, 1'b0, 2'd2, 1'b0, 24'h00ABCD, 16'h0400, 6'd32},
        row_t'{32'h0000_00F0, 1'b0, 2'd1, 1'b1, 24'h0000EE, 16'h0100, 6'd5},
        row_t'{32'h0000_0000, 1'b1, 2'd3, 1'b1, 24'h0A0B0C, 16'h0200, 6'd0},
        row_t'{32'hFFFF_0000, 1'b1, 2'd0, 1'b0, 24'h00007E, 16'h0300, 6'd0},
        row_t'{32'h0000_0006, 1'b0, 2'd2, 1'b1, 24'h003344, 16'h0050, 6'd2}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; gie_i = 1'b0; skip_i = 1'b0; src_set_i = '0; rst_req_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic post(input logic [31:0] mask, input bit rreq);
        src_set_i = mask; rst_req_i = rreq;
        @(negedge clk);
        src_set_i = '0; rst_req_i = 1'b0;
    endtask

    // called at a negedge; raises gie and follows one entry to its load cycle
    task automatic run_entry(input int vec, input logic [1:0] nb_cfg, input bit lng,
                             input logic [23:0] pc, input logic [15:0] sp,
                             input logic [31:0] set_at_load, input string tag);
        int nb, k;
        bit done;
        logic [23:0] tgt;
        nb  = (nb_cfg == 2'd3) ? 3 : (nb_cfg == 2'd2) ? 2 : 1;
        tgt = lng ? 24'(vec * 2) : 24'(vec);
        pc_i = pc; sp_i = sp; pc_bytes_i = nb_cfg; long_vec_i = lng; gie_i = 1'b1;
        k = 0; done = 1'b0;
        for (int c = 0; c < 10 && !done; c++) begin
            @(negedge clk);
            if (mem_we_o) begin
                chk(mem_addr_o == sp - 16'(k), {tag, " R6 addr"}, 32'(mem_addr_o), 32'(sp - 16'(k)));
                chk(mem_wdata_o == pc[8*k +: 8], {tag, " R6 data"}, 32'(mem_wdata_o), 32'(pc[8*k +: 8]));
                chk(busy_o, {tag, " R8 busy in write"}, 32'(busy_o), 1);
                k++;
            end
            if (pc_load_o) begin
                chk(k == nb, {tag, " R6 byte count"}, 32'(k), 32'(nb));
                chk(pc_o == tgt, {tag, " R4 target pc"}, 32'(pc_o), 32'(tgt));
                chk(gie_clr_o && sp_load_o && busy_o && !mem_we_o, {tag, " R7 strobes"},
                    {29'd0, gie_clr_o, sp_load_o, busy_o}, 32'h7);
                chk(sp_o == sp - 16'(nb), {tag, " R7 new sp"}, 32'(sp_o), 32'(sp - 16'(nb)));
                gie_i = 1'b0;
                src_set_i = set_at_load;
                done = 1'b1;
            end
        end
        chk(done, {tag, " R7 load seen"}, 32'(done), 1);
        @(negedge clk);
        src_set_i = '0;
        chk(!busy_o && !pc_load_o && !gie_clr_o, {tag, " R8 idle after load"},
            {30'd0, busy_o, pc_load_o}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] expm;
        // R9 reset state
        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_we_o && !pc_load_o && !hw_req_o && pend_o == '0, "R9 reset state",
            {pend_o[27:0], busy_o, mem_we_o, pc_load_o, hw_req_o}, 0);
        rst = 1'b0;

        // table walk
        foreach (TBL[i]) begin
            do_reset();
            post(TBL[i].mask, TBL[i].rreq);
            chk(hw_req_o == (TBL[i].mask != 0), "R5 hw_req after set", 32'(hw_req_o),
                32'(TBL[i].mask != 0));
            run_entry(int'(TBL[i].vec), TBL[i].nbyt, TBL[i].lng, TBL[i].pc, TBL[i].sp,
                      '0, $sformatf("row%0d", i));
            expm = TBL[i].mask;
            if (TBL[i].vec != 0) expm[TBL[i].vec - 1] = 1'b0;
            chk(pend_o == expm, "R5 R3 pending after entry", pend_o, expm);
        end

        // R1: skip blocks reset and hardware entry
        do_reset();
        post(32'h0000_0008, 1'b1);
        skip_i = 1'b1; gie_i = 1'b1;
        begin
            bit moved;
            moved = 1'b0;
            repeat (6) begin
                @(negedge clk);
                if (busy_o || mem_we_o) moved = 1'b1;
            end
            chk(!moved, "R1 no entry during skip", 32'(moved), 0);
        end
        skip_i = 1'b0;
        run_entry(0, 2'd2, 1'b1, 24'h000777, 16'h0180, '0, "R1 reset after skip");
        run_entry(4, 2'd2, 1'b1, 24'h000778, 16'h017E, '0, "R1 hw after skip");
        chk(pend_o == '0 && !hw_req_o, "R5 mask empties", pend_o, 0);

        // R2: gie low holds requests
        do_reset();
        post(32'h0000_0400, 1'b0);
        repeat (5) @(negedge clk);
        chk(!busy_o && pend_o == 32'h400, "R2 no entry with gie low", pend_o, 32'h400);

        // R5: successive services, lowest first
        do_reset();
        post(32'h0000_0005, 1'b0);
        run_entry(1, 2'd1, 1'b0, 24'h000011, 16'h00F0, '0, "R5 first");
        chk(pend_o == 32'h4 && hw_req_o, "R5 one left", pend_o, 32'h4);
        run_entry(3, 2'd1, 1'b0, 24'h000012, 16'h00EF, '0, "R5 second");
        chk(pend_o == '0 && !hw_req_o, "R5 hw_req drops", {pend_o[30:0], hw_req_o}, 0);

        // R10: set in the load cycle, same bit and another bit
        do_reset();
        post(32'h0000_0002, 1'b0);
        run_entry(2, 2'd1, 1'b0, 24'h000021, 16'h0090, 32'h0000_0002, "R10 same bit");
        chk(pend_o == 32'h2, "R10 same bit kept", pend_o, 32'h2);
        run_entry(2, 2'd1, 1'b0, 24'h000022, 16'h008F, 32'h0001_0000, "R10 other bit");
        chk(pend_o == 32'h0001_0000, "R10 other bit kept", pend_o, 32'h0001_0000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule